// File: doc/BRIEF.md
# Predicated Strided Multi-Register Byte Loader

This block carries out one decoded contiguous byte load whose results land in a group of two or four vector registers. The register numbers in the group are spaced apart rather than consecutive. A request brings a 64-bit base, a 64-bit element index, a group-size select, the destination fields (one high bit and a three-bit register field) and a per-element active mask that has already been expanded. The block walks the element positions in order. For each active position it issues a one-byte read on a valid/ready memory port and stores the returned byte in a staging buffer. Each inactive position is zero-filled without any memory traffic.

Register-file writes start only after every position of the group has been handled. The block then writes one vector per cycle to its strided register number and pulses a completion flag. An error response from memory abandons the operation and raises a fault pulse, and no register is written. Vector length is a parameter with a default of 16 bytes. The cycle count depends only on the mask and on the memory handshake, never on the bytes loaded.

Top module: `strided_byte_loader`

## Requirements
- R1: The first read address is `req_base_i + req_index_i`, wrapping modulo 2^64; the element size is one byte, so the index is not scaled.
- R2: Element position k of the group (k counted from 0) has address start+k modulo 2^64. The address advances by one for every position, active or not.
- R3: A position whose mask bit is 0 produces no memory read and no fault, and its destination byte is written as 0x00.
- R4: Byte e of group register r (r outer, e inner) is taken from mask bit r*VLEN_BYTES+e and from address start+r*VLEN_BYTES+e. It is placed in bits [8e+7:8e] of that register's write data.
- R5: In pair mode (`req_quad_i`=0) the first register number is {t, 0, zt[2:0]} and the second is that number plus 8. Mask bits at and above 2*VLEN_BYTES are ignored.
- R6: In quad mode (`req_quad_i`=1) the first register number is {t, 0, 0, zt[1:0]} and each following register adds 4. `req_zt_i[2]` is ignored.
- R7: No register write occurs before every position has been handled. The writes then come on consecutive cycles in ascending group order, one per register.
- R8: An error response raises `fault_o` for one cycle, skips all register writes and returns the block to idle.
- R9: `done_o` is high for exactly one cycle, in the cycle after the last register write.
- R10: `req_ready_o` is high only while idle. A request presented while busy is ignored and has no effect on the ongoing operation.
- R11: `sp_chk_o` is high for one cycle, in the cycle after acceptance, exactly when `req_base_is_sp_i` was set. This holds even when no element is active.
- R12: The number of cycles from acceptance to `done_o` is the same for two runs with the same mask and handshake timing but different loaded data.
- R13: While a memory read is waiting for `mem_req_ready_i`, `mem_req_valid_o` stays high and `mem_req_addr_o` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request taken this cycle |
| req_base_i | input | 64 | Base address |
| req_index_i | input | 64 | Element index added to base |
| req_quad_i | input | 1 | 1: four registers, 0: two registers |
| req_t_i | input | 1 | High bit of destination register number |
| req_zt_i | input | 3 | Destination register field |
| req_base_is_sp_i | input | 1 | Base comes from the stack pointer |
| req_mask_i | input | 4*VLEN_BYTES | Expanded per-element active mask |
| mem_req_valid_o | output | 1 | Byte read request |
| mem_req_ready_i | input | 1 | Memory accepts request |
| mem_req_addr_o | output | 64 | Byte read address |
| mem_rsp_valid_i | input | 1 | Read response present |
| mem_rsp_data_i | input | 8 | Read byte |
| mem_rsp_err_i | input | 1 | Read response is an error |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 5 | Destination register number |
| rf_wdata_o | output | 8*VLEN_BYTES | Vector write data |
| done_o | output | 1 | Operation complete pulse |
| fault_o | output | 1 | Memory error abort pulse |
| sp_chk_o | output | 1 | Stack-pointer alignment check flag |

## Verification
The properties assume that memory returns exactly one response for each accepted read, never sends an unsolicited one and never answers in the same cycle as the handshake. The bench responder meets this: it holds one read at a time and answers on the cycle after acceptance. It stalls reads to addresses ending in binary 11 for a cycle, so the timing depends only on the addresses. Request fields are taken only at acceptance, and the bench varies them freely while the block is busy to show they are ignored.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
  localparam int unsigned REG_W    = 5;
  localparam int unsigned MAX_REGS = 4;
  localparam int unsigned ADDR_W   = 64;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STEP,
    ST_WAIT,
    ST_WRITE,
    ST_DONE,
    ST_FAULT
  } state_e;
endpackage

// File: rtl/sbl_addr_gen.sv
module sbl_addr_gen
  import sbl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] index_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  // byte elements: index scale is 1, sums wrap mod 2^64
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= base_i + index_i;
    else if (step_i) addr_q <= addr_q + ADDR_W'(1);
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/sbl_stage_buf.sv
module sbl_stage_buf
  import sbl_pkg::*;
#(
  parameter int unsigned VLEN_BYTES = 16,
  localparam int unsigned ELEM_W = $clog2(VLEN_BYTES),
  localparam int unsigned RSEL_W = $clog2(MAX_REGS),
  localparam int unsigned VEC_W  = VLEN_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [RSEL_W-1:0] wr_reg_i,
  input  logic [ELEM_W-1:0] wr_elem_i,
  input  logic [7:0]        wr_byte_i,
  input  logic [RSEL_W-1:0] rd_reg_i,
  output logic [VEC_W-1:0]  rd_data_o
);
  logic [VEC_W-1:0] vec_q [MAX_REGS];

  for (genvar g = 0; g < MAX_REGS; g++) begin : g_vec
    // clear on accept gives the zero fill for inactive bytes
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        vec_q[g] <= '0;
      else if (clr_i)
        vec_q[g] <= '0;
      else if (we_i && (wr_reg_i == RSEL_W'(g)))
        vec_q[g][{wr_elem_i, 3'b000} +: 8] <= wr_byte_i;
    end
  end

  assign rd_data_o = vec_q[rd_reg_i];
endmodule

// File: rtl/sbl_dest_map.sv
module sbl_dest_map
  import sbl_pkg::*;
#(
  localparam int unsigned RSEL_W = $clog2(MAX_REGS)
) (
  input  logic              quad_i,
  input  logic              t_i,
  input  logic [2:0]        zt_i,
  input  logic [RSEL_W-1:0] sel_i,
  output logic [REG_W-1:0]  waddr_o
);
  logic [REG_W-1:0] first;
  logic [REG_W-1:0] offset;

  always_comb begin
    if (quad_i) begin
      first  = {t_i, 2'b00, zt_i[1:0]};
      offset = REG_W'(sel_i) << 2;
    end else begin
      first  = {t_i, 1'b0, zt_i};
      offset = REG_W'(sel_i[0]) << 3;
    end
    waddr_o = first + offset;
  end
endmodule

// File: rtl/strided_byte_loader.sv
module strided_byte_loader
  import sbl_pkg::*;
#(
  parameter int unsigned VLEN_BYTES = 16,
  localparam int unsigned MASK_W = VLEN_BYTES * MAX_REGS,
  localparam int unsigned VEC_W  = VLEN_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [63:0]       req_base_i,
  input  logic [63:0]       req_index_i,
  input  logic              req_quad_i,
  input  logic              req_t_i,
  input  logic [2:0]        req_zt_i,
  input  logic              req_base_is_sp_i,
  input  logic [MASK_W-1:0] req_mask_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [63:0]       mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [7:0]        mem_rsp_data_i,
  input  logic              mem_rsp_err_i,
  output logic              rf_we_o,
  output logic [4:0]        rf_waddr_o,
  output logic [VEC_W-1:0]  rf_wdata_o,
  output logic              done_o,
  output logic              fault_o,
  output logic              sp_chk_o
);
  localparam int unsigned ELEM_W = $clog2(VLEN_BYTES);
  localparam int unsigned POS_W  = $clog2(MASK_W);
  localparam int unsigned RSEL_W = $clog2(MAX_REGS);
  localparam logic [POS_W-1:0]  LAST_QUAD = POS_W'(MASK_W - 1);
  localparam logic [POS_W-1:0]  LAST_PAIR = POS_W'(MASK_W / 2 - 1);
  localparam logic [RSEL_W-1:0] WR_LAST_QUAD = RSEL_W'(MAX_REGS - 1);
  localparam logic [RSEL_W-1:0] WR_LAST_PAIR = RSEL_W'(1);

  state_e            state_q, state_d;
  logic [POS_W-1:0]  pos_q;
  logic [RSEL_W-1:0] wr_q;
  logic [MASK_W-1:0] mask_q;
  logic              quad_q, t_q, sp_chk_q;
  logic [2:0]        zt_q;

  logic accept, cur_active, at_last, wr_at_last, rsp_ok, step;

  assign accept     = req_valid_i && (state_q == ST_IDLE);
  assign cur_active = mask_q[pos_q];
  assign at_last    = pos_q == (quad_q ? LAST_QUAD : LAST_PAIR);
  assign wr_at_last = wr_q == (quad_q ? WR_LAST_QUAD : WR_LAST_PAIR);
  assign rsp_ok     = (state_q == ST_WAIT) && mem_rsp_valid_i && !mem_rsp_err_i;
  // every position advances the address, active or not
  assign step       = ((state_q == ST_STEP) && !cur_active) || rsp_ok;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_STEP;
      ST_STEP: begin
        if (cur_active) begin
          if (mem_req_ready_i) state_d = ST_WAIT;
        end else if (at_last) begin
          state_d = ST_WRITE;
        end
      end
      ST_WAIT: begin
        if (mem_rsp_valid_i) begin
          if (mem_rsp_err_i) state_d = ST_FAULT;
          else if (at_last)  state_d = ST_WRITE;
          else               state_d = ST_STEP;
        end
      end
      ST_WRITE: if (wr_at_last) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      ST_FAULT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      pos_q    <= '0;
      wr_q     <= '0;
      mask_q   <= '0;
      quad_q   <= 1'b0;
      t_q      <= 1'b0;
      zt_q     <= '0;
      sp_chk_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      sp_chk_q <= accept && req_base_is_sp_i;
      if (accept) begin
        pos_q  <= '0;
        wr_q   <= '0;
        mask_q <= req_mask_i;
        quad_q <= req_quad_i;
        t_q    <= req_t_i;
        zt_q   <= req_zt_i;
      end else begin
        if (step && !at_last)        pos_q <= pos_q + POS_W'(1);
        if (state_q == ST_WRITE)     wr_q  <= wr_q + RSEL_W'(1);
      end
    end
  end

  sbl_addr_gen i_addr_gen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .base_i  (req_base_i),
    .index_i (req_index_i),
    .step_i  (step),
    .addr_o  (mem_req_addr_o)
  );

  sbl_stage_buf #(.VLEN_BYTES(VLEN_BYTES)) i_stage_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (accept),
    .we_i      (rsp_ok),
    .wr_reg_i  (pos_q[POS_W-1:ELEM_W]),
    .wr_elem_i (pos_q[ELEM_W-1:0]),
    .wr_byte_i (mem_rsp_data_i),
    .rd_reg_i  (wr_q),
    .rd_data_o (rf_wdata_o)
  );

  sbl_dest_map i_dest_map (
    .quad_i  (quad_q),
    .t_i     (t_q),
    .zt_i    (zt_q),
    .sel_i   (wr_q),
    .waddr_o (rf_waddr_o)
  );

  assign req_ready_o     = state_q == ST_IDLE;
  assign mem_req_valid_o = (state_q == ST_STEP) && cur_active;
  assign rf_we_o         = state_q == ST_WRITE;
  assign done_o          = state_q == ST_DONE;
  assign fault_o         = state_q == ST_FAULT;
  assign sp_chk_o        = sp_chk_q;
endmodule

// File: rtl/sbl_checker.sv
module sbl_checker
  import sbl_pkg::*;
#(
  parameter int unsigned VLEN_BYTES = 16,
  localparam int unsigned MASK_W = VLEN_BYTES * MAX_REGS,
  localparam int unsigned POS_W  = $clog2(MASK_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic [63:0]       mem_req_addr_o,
  input logic              mem_rsp_valid_i,
  input logic              mem_rsp_err_i,
  input logic              rf_we_o,
  input logic [4:0]        rf_waddr_o,
  input logic              done_o,
  input logic              fault_o,
  input logic [MASK_W-1:0] mask_q,
  input logic [POS_W-1:0]  pos_q,
  input logic              quad_q,
  input state_e            state_q
);
  // R13
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  // R3
  no_inactive_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> mask_q[pos_q]);

  // R2
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(state_q == ST_WAIT && mem_rsp_valid_i && !mem_rsp_err_i) && mem_req_valid_o
      |-> mem_req_addr_o == $past(mem_req_addr_o) + 64'd1);

  // R10
  busy_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o || rf_we_o || done_o || fault_o) |-> !req_ready_o);

  // R9
  done_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(rf_we_o) && !rf_we_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  fault_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(mem_rsp_valid_i && mem_rsp_err_i) && !rf_we_o);

  // R7
  write_stride_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o && $past(rf_we_o)
      |-> rf_waddr_o == $past(rf_waddr_o) + (quad_q ? 5'd4 : 5'd8));
endmodule

bind strided_byte_loader sbl_checker #(.VLEN_BYTES(VLEN_BYTES)) i_sbl_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_ready_o     (req_ready_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o),
  .mem_rsp_valid_i (mem_rsp_valid_i),
  .mem_rsp_err_i   (mem_rsp_err_i),
  .rf_we_o         (rf_we_o),
  .rf_waddr_o      (rf_waddr_o),
  .done_o          (done_o),
  .fault_o         (fault_o),
  .mask_q          (mask_q),
  .pos_q           (pos_q),
  .quad_q          (quad_q),
  .state_q         (state_q)
);

// File: tb/test_strided_byte_loader.sv
`timescale 1ns/1ps
module test_strided_byte_loader;
  localparam int VL     = 16;
  localparam int MASK_W = VL * 4;
  localparam int VEC_W  = VL * 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic [63:0]       req_base_i = '0, req_index_i = '0;
  logic              req_quad_i = 1'b0, req_t_i = 1'b0, req_base_is_sp_i = 1'b0;
  logic [2:0]        req_zt_i = '0;
  logic [MASK_W-1:0] req_mask_i = '0;
  logic              mem_req_valid_o, mem_req_ready_i;
  logic [63:0]       mem_req_addr_o;
  logic              mem_rsp_valid_i, mem_rsp_err_i;
  logic [7:0]        mem_rsp_data_i;
  logic              rf_we_o, done_o, fault_o, sp_chk_o;
  logic [4:0]        rf_waddr_o;
  logic [VEC_W-1:0]  rf_wdata_o;

  always #2 clk_i = ~clk_i;

  strided_byte_loader #(.VLEN_BYTES(VL)) i_strided_byte_loader (.*);

  int n_chk = 0, n_fail = 0;
  longint cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  // scoreboard state
  logic [4:0]       exp_addr_q[$];
  logic [VEC_W-1:0] exp_data_q[$];
  logic [63:0]      cur_start;
  logic [MASK_W-1:0] cur_mask;
  int               cur_n = 0;
  logic [7:0]       seed = 8'h00;
  logic             err_en = 1'b0;
  logic [63:0]      err_addr = '0;
  int               reads = 0, bad_reads = 0;

  task automatic chk(input bit ok, input string tag, input logic [VEC_W-1:0] act,
                     input logic [VEC_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [63:0] a);
    return a[7:0] ^ a[23:16] ^ a[63:56] ^ seed;
  endfunction

  // memory responder: one read in flight, stalls addresses ending in 2'b11 once
  initial begin
    logic pending, waited;
    logic [63:0] pend_addr;
    pending = 0; waited = 0; pend_addr = '0;
    mem_req_ready_i = 0; mem_rsp_valid_i = 0; mem_rsp_err_i = 0; mem_rsp_data_i = '0;
    forever begin
      @(negedge clk_i);
      mem_rsp_valid_i = 0; mem_rsp_err_i = 0; mem_req_ready_i = 0;
      if (pending) begin
        mem_rsp_valid_i = 1;
        mem_rsp_data_i  = mem_byte(pend_addr);
        mem_rsp_err_i   = err_en && (pend_addr == err_addr);
        pending = 0;
      end else if (mem_req_valid_o) begin
        if (mem_req_addr_o[1:0] == 2'b11 && !waited) waited = 1;
        else begin
          logic [63:0] k;
          waited = 0;
          mem_req_ready_i = 1;
          pend_addr = mem_req_addr_o;
          pending = 1;
          reads++;
          k = mem_req_addr_o - cur_start;
          if (k >= 64'(cur_n * VL) || !cur_mask[k[5:0]]) bad_reads++;
        end
      end
    end
  end

  // monitor: pop expected writes
  initial begin
    logic prev_we;
    prev_we = 0;
    forever begin
      @(negedge clk_i);
      if (rf_we_o) begin
        if (exp_addr_q.size() == 0) begin
          chk(0, "R8 unexpected write", VEC_W'(rf_waddr_o), '0);
        end else begin
          logic [4:0] ea;
          logic [VEC_W-1:0] ed;
          ea = exp_addr_q.pop_front();
          ed = exp_data_q.pop_front();
          chk(rf_waddr_o == ea, "R5/R6 waddr", VEC_W'(rf_waddr_o), VEC_W'(ea));
          chk(rf_wdata_o == ed, "R3/R4 wdata", rf_wdata_o, ed);
        end
      end
      if (done_o) begin
        chk(prev_we, "R9 done after last write", VEC_W'(prev_we), 1);
        chk(exp_addr_q.size() == 0, "R7 all writes before done", VEC_W'(exp_addr_q.size()), 0);
      end
      prev_we = rf_we_o;
    end
  end

  task automatic run(input logic [63:0] base, input logic [63:0] index, input bit quad,
                     input bit t, input logic [2:0] zt, input logic [MASK_W-1:0] mask,
                     input bit is_sp, input bit exp_fault, input int hold_busy,
                     output longint cycles);
    logic [4:0] first, stride;
    int n, nact;
    longint t0;
    n = quad ? 4 : 2;
    first  = quad ? {t, 2'b00, zt[1:0]} : {t, 1'b0, zt};
    stride = quad ? 5'd4 : 5'd8;
    cur_start = base + index;
    cur_n = n;
    cur_mask = mask;
    reads = 0; bad_reads = 0; nact = 0;
    for (int r = 0; r < n; r++) begin
      logic [VEC_W-1:0] v;
      v = '0;
      for (int e = 0; e < VL; e++) begin
        int k;
        k = r * VL + e;
        if (mask[k]) begin
          v[e*8 +: 8] = mem_byte(cur_start + 64'(k));
          nact++;
        end
      end
      if (!exp_fault) begin
        exp_addr_q.push_back(first + 5'(r) * stride);
        exp_data_q.push_back(v);
      end
    end
    @(negedge clk_i);
    chk(req_ready_o, "R10 ready when idle", VEC_W'(req_ready_o), 1);
    req_base_i = base; req_index_i = index; req_quad_i = quad; req_t_i = t;
    req_zt_i = zt; req_mask_i = mask; req_base_is_sp_i = is_sp; req_valid_i = 1;
    @(posedge clk_i);
    t0 = cyc;
    @(negedge clk_i);
    chk(sp_chk_o == is_sp, "R11 sp check flag", VEC_W'(sp_chk_o), VEC_W'(is_sp));
    // R10: garbage request while busy must be ignored
    req_base_i = ~base; req_zt_i = ~zt; req_mask_i = ~mask; req_quad_i = ~quad;
    req_base_is_sp_i = 1;
    for (int i = 0; i < hold_busy; i++) begin
      chk(!req_ready_o, "R10 not ready while busy", VEC_W'(req_ready_o), 0);
      @(negedge clk_i);
    end
    req_valid_i = 0;
    while (!(done_o || fault_o)) @(negedge clk_i);
    cycles = cyc - t0;
    chk(fault_o == exp_fault, "R8 fault outcome", VEC_W'(fault_o), VEC_W'(exp_fault));
    chk(!done_o == exp_fault, "R9 done outcome", VEC_W'(done_o), VEC_W'(!exp_fault));
    chk(bad_reads == 0, "R3 read of inactive or out-of-group byte", VEC_W'(bad_reads), 0);
    if (!exp_fault)
      chk(reads == nact, "R2 read count", VEC_W'(reads), VEC_W'(nact));
    @(negedge clk_i);
    chk(!done_o && !fault_o, "R9 single-cycle pulse", VEC_W'({done_o, fault_o}), 0);
    if (exp_fault) begin
      chk(exp_addr_q.size() == 0, "R8 no writes", VEC_W'(exp_addr_q.size()), 0);
      chk(req_ready_o, "R8 back to idle", VEC_W'(req_ready_o), 1);
    end
  endtask

  initial begin
    #(4 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    longint c0, c1;
    repeat (3) @(negedge clk_i);
    chk(req_ready_o && !rf_we_o && !mem_req_valid_o && !done_o && !fault_o && !sp_chk_o,
        "R10 reset state", VEC_W'({req_ready_o, rf_we_o, mem_req_valid_o, done_o, fault_o}),
        VEC_W'(5'b10000));
    rst_ni = 1;
    // R1 R4 R5: pair, all active, regs 3 and 11
    seed = 8'h11;
    run(64'h1000, 64'd5, 0, 0, 3'd3, {MASK_W{1'b1}}, 0, 0, 0, c0);
    // R6: quad, mixed mask, zt[2] ignored -> regs 18,22,26,30
    seed = 8'h27;
    run(64'h2_0000_0040, 64'h13, 1, 1, 3'b110, 64'hF0F0_1234_8001_A5A5, 0, 0, 0, c0);
    // R3 R11: no active element, zero fill, sp flagged anyway
    run(64'h3000, 64'h0, 0, 1, 3'd5, '0, 1, 0, 0, c0);
    // R1 R2: wrap across 2^64
    seed = 8'h5C;
    run(64'hFFFF_FFFF_FFFF_FFF0, 64'd8, 1, 0, 3'd1, {MASK_W{1'b1}}, 0, 0, 0, c0);
    // R5: pair with upper mask bits set (ignored)
    run(64'h4000, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 3'd7, {32'hFFFF_FFFF, 32'h0F0F_3C3C}, 0, 0, 0, c0);
    // R8: error response mid-sequence
    err_en = 1; err_addr = 64'h5000 + 64'd2 + 64'd20;
    run(64'h5000, 64'd2, 1, 0, 3'd2, {MASK_W{1'b1}}, 0, 1, 0, c0);
    err_en = 0;
    // R10: busy requests ignored
    seed = 8'h3A;
    run(64'h6000, 64'd1, 1, 1, 3'd3, 64'h0123_4567_89AB_CDEF, 1, 0, 6, c0);
    // R12: same mask, different data
    seed = 8'h00;
    run(64'h7000, 64'd9, 1, 0, 3'd0, 64'h8888_1111_FFFF_0F0F, 0, 0, 0, c0);
    seed = 8'hC3;
    run(64'h7000, 64'd9, 1, 0, 3'd0, 64'h8888_1111_FFFF_0F0F, 0, 0, 0, c1);
    chk(c0 == c1, "R12 data-independent timing", VEC_W'(c1), VEC_W'(c0));
    repeat (2) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule